// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Bank

This block holds a small bank of address-match triggers for a 64-bit hart. Each trigger has a control word and a compare value. Every cycle, each trigger compares its value against the presented instruction-fetch address and the presented load/store address. A trigger counts only if its access kind and the current privilege are enabled in its control word. Chained triggers combine by AND. The block then reports, on each channel and in the same cycle, whether a trigger fired, whether the hart should take a breakpoint exception or enter debug mode, and the index of the trigger that won.

Control words are legalized when they are written, so the stored word only ever holds supported encodings. Software-visible decoding of register addresses sits outside the block. It drives the write port, the readback index and the machine-mode trigger-enable pair (current and previous) that trap entry and return update. The outputs are meant to feed the exception and debug-entry logic directly.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset every control word reads 0xF000_0000_0000_0000 (type 15, all other bits zero), every compare value reads 0, `tctl_q` reads 0, and neither channel fires.
- R2: The control word type sits in bits 63:60, and only type 2 is legal. A write with any other type stores type 15 with bits 58:0 cleared, and such a disabled trigger never hits.
- R3: The match field sits in bits 10:7. Code 0 means equal, 2 means unsigned greater-or-equal and 3 means unsigned less-than, each comparing the address against the compare value. Any other written code is stored as 0.
- R4: Hit outputs are combinational: they reflect the stored words, the address inputs and the state inputs in the same cycle, with no register in the path.
- R5: Bit 2 enables matching of `fetch_addr` when `fetch_valid` is set. Bit 1 enables matching of `mem_addr` for stores and bit 0 for loads, with `mem_is_store` set meaning store, and only when `mem_valid` is set.
- R6: The `priv` input uses 0 for user, 1 for supervisor and 3 for machine mode. A hit counts only when control bit 3 (user), bit 4 (supervisor) or bit 6 (machine) matches the current mode, and never when `priv` is 2.
- R7: The debug-only bit (59) is stored as 1 only if written as 1 while `dbg_mode` is high. The action field (15:12) keeps code 1 (enter debug mode) only when the stored debug-only bit is 1, and every other value is stored as 0 (breakpoint exception).
- R8: After any write of a legal type, bits 58:53, 22:20, 18:16, 5 and 52:23 read zero. The select bit (19) is kept only when bit 2 is also written as 1.
- R9: Chain bit 11 links a trigger to the next index. A group of linked triggers fires only when all of its members hit. It takes the action of its last member and is reported by the index of its first member.
- R10: A written chain bit is dropped when the index is the last one, or when keeping it would put CHAIN_LEN chain bits at consecutive indices.
- R11: `tctl_q[0]` is the machine-mode enable and `tctl_q[1]` the previous enable. Machine-mode hits need `tctl_q[0]`. `trap_to_m` copies bit 0 into bit 1 and clears bit 0. `mret` copies bit 1 into bit 0. `tctl_we` loads `tctl_wdata`. When several arrive together, trap beats return and return beats write.
- R12: If any firing group on a channel has the debug action, the channel reports `*_dbg`=1 and the lowest such group index. Otherwise it reports `*_dbg`=0 and the lowest firing group index.
- R13: Nothing fires while `dbg_mode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a trigger register |
| cfg_sel | input | 1 | 0 selects the control word, 1 the compare value |
| cfg_idx | input | IW | Trigger index written |
| cfg_wdata | input | XLEN | Write data |
| tctl_we | input | 1 | Write strobe for the enable pair |
| tctl_wdata | input | 2 | {previous enable, enable} |
| trap_to_m | input | 1 | Trap entry into machine mode |
| mret | input | 1 | Return from machine mode |
| priv | input | 2 | Current privilege |
| dbg_mode | input | 1 | Hart is in debug mode |
| fetch_valid | input | 1 | Fetch address is valid |
| fetch_addr | input | XLEN | Fetch address |
| mem_valid | input | 1 | Memory access is valid |
| mem_is_store | input | 1 | 1 for store, 0 for load |
| mem_addr | input | XLEN | Load/store address |
| rd_idx | input | IW | Readback index |
| rd_ctrl | output | XLEN | Stored control word of `rd_idx` |
| rd_cmp | output | XLEN | Stored compare value of `rd_idx` |
| tctl_q | output | 2 | {previous enable, enable} |
| fetch_fire | output | 1 | A fetch trigger group fired |
| fetch_dbg | output | 1 | Fetch action: 1 debug entry, 0 breakpoint |
| fetch_idx | output | IW | Index of the reported fetch group |
| mem_fire | output | 1 | A load/store trigger group fired |
| mem_dbg | output | 1 | Memory action: 1 debug entry, 0 breakpoint |
| mem_idx | output | IW | Index of the reported memory group |

## Verification
The bench builds the block with four triggers, 64-bit addresses and a chain limit of two. That makes the last-index chain rule and the two-in-a-row chain rule reachable with a few writes. The four triggers also leave room for two separate groups plus a disabled slot between them, which exercises group starts, the debug-over-breakpoint priority and the lowest-index choice. Full 64-bit values let the unsigned compares be tried at the top address bit.

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit #(
  parameter int NTRIG     = 4,
  parameter int XLEN      = 64,
  parameter int CHAIN_LEN = 2,
  localparam int IW       = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [XLEN-1:0] cfg_wdata,
  input  logic            tctl_we,
  input  logic [1:0]      tctl_wdata,
  input  logic            trap_to_m,
  input  logic            mret,
  input  logic [1:0]      priv,
  input  logic            dbg_mode,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_addr,
  input  logic            mem_valid,
  input  logic            mem_is_store,
  input  logic [XLEN-1:0] mem_addr,
  input  logic [IW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_ctrl,
  output logic [XLEN-1:0] rd_cmp,
  output logic [1:0]      tctl_q,
  output logic            fetch_fire,
  output logic            fetch_dbg,
  output logic [IW-1:0]   fetch_idx,
  output logic            mem_fire,
  output logic            mem_dbg,
  output logic [IW-1:0]   mem_idx
);
  localparam int TY = XLEN - 1;
  localparam int DM = XLEN - 5;

  logic [XLEN-1:0] ctrl [NTRIG];
  logic [XLEN-1:0] cmpv [NTRIG];
  logic            mte, mpte;
  logic [NTRIG-1:0] chn_v, act_v, start_v, hit_f, hit_m;
  logic [XLEN-1:0] nctl;
  logic            chain_ok, new_dm;
  logic            unused_wd;

  assign tctl_q    = {mpte, mte};
  assign rd_ctrl   = (int'(rd_idx) < NTRIG) ? ctrl[rd_idx] : '0;
  assign rd_cmp    = (int'(rd_idx) < NTRIG) ? cmpv[rd_idx] : '0;
  assign unused_wd = ^cfg_wdata;
  assign start_v   = ~{chn_v[NTRIG-2:0], 1'b0};

  function automatic logic addr_cmp(input logic [XLEN-1:0] a, input logic [XLEN-1:0] t,
                                    input logic [3:0] m);
    case (m)
      4'd0:    return a == t;
      4'd2:    return a >= t;
      4'd3:    return a < t;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    logic [NTRIG-1:0] cand;
    logic run;
    cand = chn_v;
    if (int'(cfg_idx) < NTRIG) cand[cfg_idx] = 1'b1;
    chain_ok = (int'(cfg_idx) != NTRIG - 1);
    for (int s = 0; s <= NTRIG - CHAIN_LEN; s++) begin
      run = 1'b1;
      for (int k = 0; k < CHAIN_LEN; k++) run = run & cand[s+k];
      if (run) chain_ok = 1'b0;
    end
  end

  always_comb begin
    logic [3:0] mt;
    new_dm = cfg_wdata[DM] & dbg_mode;
    mt     = cfg_wdata[10:7];
    nctl   = '0;
    if (cfg_wdata[TY -: 4] != 4'd2) begin
      nctl[TY -: 4] = 4'hF;
      nctl[DM]      = new_dm;
    end else begin
      nctl[TY -: 4] = 4'd2;
      nctl[DM]      = new_dm;
      nctl[19]      = cfg_wdata[19] & cfg_wdata[2];
      nctl[15:12]   = (cfg_wdata[15:12] == 4'd1 && new_dm) ? 4'd1 : 4'd0;
      nctl[11]      = cfg_wdata[11] & chain_ok;
      nctl[10:7]    = (mt == 4'd0 || mt == 4'd2 || mt == 4'd3) ? mt : 4'd0;
      nctl[6]       = cfg_wdata[6];
      nctl[4:0]     = cfg_wdata[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTRIG; i++) begin
        ctrl[i] <= {4'hF, {(XLEN-4){1'b0}}};
        cmpv[i] <= '0;
      end
    end else if (cfg_we && int'(cfg_idx) < NTRIG) begin
      if (cfg_sel) cmpv[cfg_idx] <= cfg_wdata;
      else         ctrl[cfg_idx] <= nctl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mte  <= 1'b0;
      mpte <= 1'b0;
    end else if (trap_to_m) begin
      mpte <= mte;
      mte  <= 1'b0;
    end else if (mret) begin
      mte  <= mpte;
    end else if (tctl_we) begin
      {mpte, mte} <= tctl_wdata;
    end
  end

  for (genvar i = 0; i < NTRIG; i++) begin : g_trig
    logic [XLEN-1:0] c;
    logic pok, en;
    assign c     = ctrl[i];
    assign pok   = (priv == 2'd3 && c[6] && mte) || (priv == 2'd1 && c[4]) ||
                   (priv == 2'd0 && c[3]);
    assign en    = (c[TY -: 4] == 4'd2) && pok && !dbg_mode;
    assign chn_v[i] = c[11];
    assign act_v[i] = c[12];
    assign hit_f[i] = en && fetch_valid && c[2] && addr_cmp(fetch_addr, cmpv[i], c[10:7]);
    assign hit_m[i] = en && mem_valid && (mem_is_store ? c[1] : c[0]) &&
                      addr_cmp(mem_addr, cmpv[i], c[10:7]);
  end

  function automatic logic [IW+1:0] resolve(input logic [NTRIG-1:0] h);
    logic [NTRIG-1:0] tok, tact;
    logic anyd, anyb;
    logic [IW-1:0] id, ib;
    tok[NTRIG-1]  = h[NTRIG-1];
    tact[NTRIG-1] = act_v[NTRIG-1];
    for (int i = NTRIG - 2; i >= 0; i--) begin
      tok[i]  = h[i] & (chn_v[i] ? tok[i+1] : 1'b1);
      tact[i] = chn_v[i] ? tact[i+1] : act_v[i];
    end
    anyd = 1'b0; anyb = 1'b0; id = '0; ib = '0;
    for (int i = NTRIG - 1; i >= 0; i--) begin
      if (tok[i] && start_v[i]) begin
        if (tact[i]) begin anyd = 1'b1; id = IW'(i); end
        else         begin anyb = 1'b1; ib = IW'(i); end
      end
    end
    if (anyd)      return {1'b1, 1'b1, id};
    else if (anyb) return {1'b1, 1'b0, ib};
    else           return '0;
  endfunction

  assign {fetch_fire, fetch_dbg, fetch_idx} = resolve(hit_f);
  assign {mem_fire, mem_dbg, mem_idx}       = resolve(hit_m);
endmodule

module dbg_trig_unit_chk #(
  parameter int NTRIG     = 4,
  parameter int XLEN      = 64,
  parameter int CHAIN_LEN = 2,
  localparam int IW       = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_to_m,
  input logic            mret,
  input logic [1:0]      priv,
  input logic            dbg_mode,
  input logic            fetch_valid,
  input logic            mem_valid,
  input logic [XLEN-1:0] rd_ctrl,
  input logic [1:0]      tctl_q,
  input logic            fetch_fire,
  input logic            mem_fire
);
  assert_type_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl[XLEN-1 -: 4] == 4'd2 || rd_ctrl[XLEN-1 -: 4] == 4'hF);
  assert_match_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl[10:7] == 4'd0 || rd_ctrl[10:7] == 4'd2 || rd_ctrl[10:7] == 4'd3);
  assert_fetch_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |-> fetch_valid);
  assert_mem_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |-> mem_valid);
  assert_priv_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    priv == 2'd2 |-> !fetch_fire && !mem_fire);
  assert_dbg_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl[12] |-> rd_ctrl[XLEN-5]);
  assert_fixed_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ctrl[20] && !rd_ctrl[18]);
  assert_trap_save_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_to_m |=> tctl_q == {$past(tctl_q[0]), 1'b0});
  assert_mret_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mret && !trap_to_m |=> tctl_q[0] == $past(tctl_q[1]));
  assert_dbg_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |-> !fetch_fire && !mem_fire);
endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(.NTRIG(NTRIG), .XLEN(XLEN), .CHAIN_LEN(CHAIN_LEN)) i_chk (.*);

// File: tb/test_dbg_trig_unit.sv
module test_dbg_trig_unit;
  localparam int NT = 4, XL = 64, IW = 2;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0, tctl_we = 0, trap_to_m = 0, mret = 0, dbg_mode = 0;
  logic [IW-1:0] cfg_idx = 0, rd_idx = 0;
  logic [XL-1:0] cfg_wdata = 0, fetch_addr = 0, mem_addr = 0;
  logic [1:0] tctl_wdata = 0, priv = 0;
  logic fetch_valid = 0, mem_valid = 0, mem_is_store = 0;
  logic [XL-1:0] rd_ctrl, rd_cmp;
  logic [1:0] tctl_q;
  logic fetch_fire, fetch_dbg, mem_fire, mem_dbg;
  logic [IW-1:0] fetch_idx, mem_idx;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dbg_trig_unit #(.NTRIG(NT), .XLEN(XL), .CHAIN_LEN(2)) i_dbg_trig_unit (.*);

  task automatic chk(input string req, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [XL-1:0] mk(input logic [3:0] ty, input logic dm, input logic [3:0] ac,
      input logic ch, input logic [3:0] mt, input logic [5:0] en);
    logic [XL-1:0] v = '0;
    v[63:60] = ty; v[59] = dm; v[15:12] = ac; v[11] = ch; v[10:7] = mt;
    v[6] = en[5]; v[4] = en[4]; v[3] = en[3]; v[2:0] = en[2:0];
    return v;
  endfunction

  task automatic wr(input int idx, input logic sel, input logic [XL-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_idx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input int idx);
    rd_idx = IW'(idx); #1;
  endtask

  task automatic fetch(input logic [XL-1:0] a);
    @(negedge clk); fetch_valid = 1; fetch_addr = a; #2;
  endtask

  task automatic mem(input logic st, input logic [XL-1:0] a);
    @(negedge clk); mem_valid = 1; mem_is_store = st; mem_addr = a; #2;
  endtask

  task automatic clear_all();
    @(negedge clk); fetch_valid = 0; mem_valid = 0; dbg_mode = 0; priv = 0;
    for (int i = 0; i < NT; i++) begin wr(i, 0, '0); wr(i, 1, '0); end
    @(negedge clk); tctl_we = 1; tctl_wdata = 0;
    @(negedge clk); tctl_we = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < NT; i++) begin
      rd(i);
      chk("R1 ctrl", rd_ctrl, 64'hF000_0000_0000_0000);
      chk("R1 cmp", rd_cmp, 0);
    end
    chk("R1 tctl", tctl_q, 0);
    priv = 3; fetch(0); mem(0, 0);
    chk("R1 fetch_fire", fetch_fire, 0);
    chk("R1 mem_fire", mem_fire, 0);
  endtask

  task automatic t_type();
    clear_all();
    wr(0, 0, mk(4'd3, 0, 0, 0, 0, 6'b011111));
    rd(0); chk("R2 illegal type", rd_ctrl, 64'hF000_0000_0000_0000);
    wr(0, 1, 0); fetch(0);
    chk("R2 disabled no hit", fetch_fire, 0);
    wr(0, 0, mk(4'd2, 0, 0, 0, 0, 6'b001100));
    rd(0); chk("R2 legal type", rd_ctrl, mk(4'd2, 0, 0, 0, 0, 6'b001100));
  endtask

  task automatic t_match();
    clear_all();
    wr(0, 0, mk(2, 0, 0, 0, 4'd1, 6'b001100)); rd(0); chk("R3 napot->eq", rd_ctrl[10:7], 0);
    wr(0, 0, mk(2, 0, 0, 0, 4'd13, 6'b001100)); rd(0); chk("R3 13->eq", rd_ctrl[10:7], 0);
    wr(0, 0, mk(2, 0, 0, 0, 4'd3, 6'b001100)); rd(0); chk("R3 lt kept", rd_ctrl[10:7], 3);
  endtask

  task automatic t_cmp();
    clear_all();
    wr(0, 1, 64'h1000);
    wr(0, 0, mk(2, 0, 0, 0, 0, 6'b001100));
    fetch(64'h1000); chk("R4 eq hit", fetch_fire, 1); chk("R4 eq idx", fetch_idx, 0);
    fetch(64'h1004); chk("R4 eq miss", fetch_fire, 0);
    wr(0, 0, mk(2, 0, 0, 0, 2, 6'b001100));
    fetch(64'h1000); chk("R3 ge equal", fetch_fire, 1);
    fetch(64'h8000_0000_0000_0000); chk("R3 ge unsigned top", fetch_fire, 1);
    fetch(64'hFFF); chk("R3 ge below", fetch_fire, 0);
    wr(0, 0, mk(2, 0, 0, 0, 3, 6'b001100));
    fetch(64'hFFF); chk("R3 lt below", fetch_fire, 1);
    fetch(64'h1000); chk("R3 lt equal", fetch_fire, 0);
    fetch(64'h8000_0000_0000_0000); chk("R3 lt unsigned top", fetch_fire, 0);
  endtask

  task automatic t_kind();
    clear_all();
    wr(1, 1, 64'h80);
    wr(1, 0, mk(2, 0, 0, 0, 0, 6'b001001));
    mem(0, 64'h80); chk("R5 load hit", mem_fire, 1); chk("R5 load idx", mem_idx, 1);
    mem(1, 64'h80); chk("R5 store off", mem_fire, 0);
    fetch(64'h80); chk("R5 fetch off", fetch_fire, 0);
    @(negedge clk); fetch_valid = 0;
    wr(1, 0, mk(2, 0, 0, 0, 0, 6'b001010));
    mem(1, 64'h80); chk("R5 store hit", mem_fire, 1);
    @(negedge clk); mem_valid = 0; #2; chk("R5 invalid mem", mem_fire, 0);
  endtask

  task automatic t_priv();
    clear_all();
    wr(0, 0, mk(2, 0, 0, 0, 0, 6'b010100));
    priv = 1; fetch(0); chk("R6 S hit", fetch_fire, 1);
    priv = 0; fetch(0); chk("R6 U off", fetch_fire, 0);
    priv = 3; fetch(0); chk("R6 M off", fetch_fire, 0);
    wr(0, 0, mk(2, 0, 0, 0, 0, 6'b111100));
    priv = 2; fetch(0); chk("R6 rsvd priv", fetch_fire, 0);
  endtask

  task automatic t_mte();
    clear_all();
    wr(0, 0, mk(2, 0, 0, 0, 0, 6'b100100));
    priv = 3; fetch(0); chk("R11 mte clear", fetch_fire, 0);
    @(negedge clk); tctl_we = 1; tctl_wdata = 2'b01;
    @(negedge clk); tctl_we = 0; #2;
    chk("R11 write", tctl_q, 2'b01); chk("R11 mte set", fetch_fire, 1);
    @(negedge clk); trap_to_m = 1;
    @(negedge clk); trap_to_m = 0; #2;
    chk("R11 trap", tctl_q, 2'b10); chk("R11 trap gate", fetch_fire, 0);
    @(negedge clk); mret = 1;
    @(negedge clk); mret = 0; #2;
    chk("R11 mret", tctl_q, 2'b11); chk("R11 mret fire", fetch_fire, 1);
    @(negedge clk); trap_to_m = 1; mret = 1; tctl_we = 1; tctl_wdata = 2'b00;
    @(negedge clk); trap_to_m = 0; mret = 0; tctl_we = 0; #2;
    chk("R11 trap priority", tctl_q, 2'b10);
    @(negedge clk); mret = 1; tctl_we = 1; tctl_wdata = 2'b00;
    @(negedge clk); mret = 0; tctl_we = 0; #2;
    chk("R11 mret over write", tctl_q, 2'b11);
  endtask

  task automatic t_action();
    clear_all();
    wr(0, 0, mk(2, 1, 1, 0, 0, 6'b001100));
    rd(0); chk("R7 dmode outside debug", rd_ctrl[59], 0); chk("R7 action dropped", rd_ctrl[15:12], 0);
    dbg_mode = 1;
    wr(0, 0, mk(2, 1, 1, 0, 0, 6'b001100));
    wr(1, 0, mk(2, 0, 1, 0, 0, 6'b001100));
    rd(0); chk("R7 dmode kept", rd_ctrl[59], 1); chk("R7 action kept", rd_ctrl[15:12], 1);
    rd(1); chk("R7 action needs dmode", rd_ctrl[15:12], 0);
    wr(0, 0, mk(2, 1, 4'd2, 0, 0, 6'b001100));
    rd(0); chk("R7 trace code", rd_ctrl[15:12], 0);
    wr(0, 0, mk(2, 1, 1, 0, 0, 6'b001100));
    fetch(0); chk("R13 quiet in debug", fetch_fire, 0);
    @(negedge clk); dbg_mode = 0; #2;
    chk("R7 debug action", {fetch_fire, fetch_dbg}, 2'b11);
  endtask

  task automatic t_fixed();
    clear_all();
    wr(1, 0, {4'h2, 60'hFFF_FFFF_FFFF_FFFF});
    rd(1); chk("R8 fixed fields", rd_ctrl, 64'h2000_0000_0008_085F);
    wr(1, 0, mk(2, 0, 0, 0, 0, 6'b001000) | 64'h8_0000);
    rd(1); chk("R8 select needs exec", rd_ctrl[19], 0);
  endtask

  task automatic t_chain_legal();
    clear_all();
    wr(0, 0, mk(2, 0, 0, 1, 0, 6'b001100)); rd(0); chk("R10 chain kept", rd_ctrl[11], 1);
    wr(1, 0, mk(2, 0, 0, 1, 0, 6'b001100)); rd(1); chk("R10 run too long", rd_ctrl[11], 0);
    wr(3, 0, mk(2, 0, 0, 1, 0, 6'b001100)); rd(3); chk("R10 last index", rd_ctrl[11], 0);
    wr(2, 0, mk(2, 0, 0, 1, 0, 6'b001100)); rd(2); chk("R10 separate run", rd_ctrl[11], 1);
  endtask

  task automatic t_chain();
    clear_all();
    dbg_mode = 1;
    wr(1, 1, 64'h2000);
    wr(1, 0, mk(2, 1, 1, 0, 2, 6'b001100));
    dbg_mode = 0;
    wr(0, 1, 64'h3000);
    wr(0, 0, mk(2, 0, 0, 1, 0, 6'b001100));
    fetch(64'h3000);
    chk("R9 group fires", {fetch_fire, fetch_dbg, 1'b0, fetch_idx}, {2'b11, 1'b0, 2'd0});
    fetch(64'h2500); chk("R9 tail alone", fetch_fire, 0);
    fetch(64'h1000); chk("R9 none", fetch_fire, 0);
  endtask

  task automatic t_prio();
    clear_all();
    wr(0, 1, 64'h40); wr(2, 1, 64'h40); wr(3, 1, 64'h40);
    wr(0, 0, mk(2, 0, 0, 0, 0, 6'b001100));
    dbg_mode = 1;
    wr(2, 0, mk(2, 1, 1, 0, 0, 6'b001100));
    wr(3, 0, mk(2, 1, 1, 0, 0, 6'b001100));
    dbg_mode = 0;
    fetch(64'h40);
    chk("R12 debug wins", {fetch_fire, fetch_dbg, 1'b0, fetch_idx}, {2'b11, 1'b0, 2'd2});
    wr(2, 0, mk(2, 0, 0, 0, 0, 6'b001100));
    #2;
    chk("R12 debug from idx3", {fetch_fire, fetch_dbg, 1'b0, fetch_idx}, {2'b11, 1'b0, 2'd3});
    wr(3, 0, mk(2, 0, 0, 0, 0, 6'b001100));
    #2;
    chk("R12 lowest bkpt", {fetch_fire, fetch_dbg, 1'b0, fetch_idx}, {2'b10, 1'b0, 2'd0});
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_type();
    t_match();
    t_cmp();
    t_kind();
    t_priv();
    t_mte();
    t_action();
    t_fixed();
    t_chain_legal();
    t_chain();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule